// File: doc/BRIEF.md
# Two-Source Interrupt Level Merger and Vector Responder

This block sits between two serial peripherals, an asynchronous serial port and a queued SPI engine, and a processor's prioritized interrupt input. Each peripheral presents a level-sensitive pending flag. The block holds a programmable priority level for each of them and a shared vector base. From these it drives a one-hot interrupt request bus that shows the single most urgent level. The processor answers a request with an acknowledge cycle that carries the level it is servicing. The block then compares that level with the level of each pending source. When one matches, it returns a vector that combines the shared base with a source-identifying low bit.

Software reaches the three registers through a byte-wide port with a 2-bit select. The block never clears a pending flag. Each peripheral drops its own flag once its handler has run. Writes take effect at the clock edge. Reads, the request bus and the acknowledge response are combinational from the registers and inputs.

Top module: `irq_pair_merge`

## Requirements
- R1: After reset both source levels are 0, the vector register reads 0x0F, and `irq_req` is all zeros.
- R2: Select 0 addresses the serial-port level and select 1 the SPI level. A write stores data bits 2:0, and a read returns the stored level in bits 2:0 with bits 7:3 reading as zero. Select 3 is reserved and reads as zero.
- R3: Select 2 addresses the vector register. A write stores data bits 7:1 and ignores bit 0, which always reads as 1.
- R4: A pending source with a level L from 1 to 7 drives only `irq_req` bit L-1. A source at level 0, or one that is not pending, drives no line.
- R5: When both sources are pending at different non-zero levels, only the line of the higher level is asserted.
- R6: When both sources are pending at the same non-zero level, exactly that one line is asserted.
- R7: During `iack`, if `iack_lvl` equals the level of exactly one pending source, `vec_valid` is 1 and `vec_out` is the vector bits 7:1 with bit 0 set to 0 for the serial port or to 1 for the SPI engine.
- R8: During `iack`, if both pending sources share the acknowledged level, the SPI engine is served and `vec_out` bit 0 is 1.
- R9: During `iack`, if no pending source has the acknowledged level, `vec_valid` is 0 and `vec_out` is 0. Without `iack`, `vec_valid` is 0.
- R10: An acknowledge at level 0 never produces a response, even when a source is pending with a level of 0.
- R11: An acknowledge does not clear a pending request. `irq_req` stays asserted for as long as the pending input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 serial level, 1 SPI level, 2 vector, 3 reserved |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ser_pend | input | 1 | Serial port interrupt pending (level) |
| spi_pend | input | 1 | SPI engine interrupt pending (level) |
| irq_req | output | 7 | One-hot request bus; bit L-1 means level L |
| iack | input | 1 | Interrupt acknowledge cycle in progress |
| iack_lvl | input | 3 | Level being acknowledged |
| vec_valid | output | 1 | Block answers this acknowledge |
| vec_out | output | 8 | Vector returned on a matching acknowledge |

## Verification
The bench concentrates on the boundaries of the arbitration and matching rules. A tie at equal levels must yield one request line and an SPI vector; a design that favours the serial port would return an even vector. Two different levels must show only the higher line; an OR of both decodes would raise two lines. An acknowledge at a level held by neither source, or at level 0, must stay silent; a design that matched disabled sources would answer spuriously. Writes with bit 0 or the reserved upper level bits set check that the vector LSB still reads 1 and that reserved bits read 0, which catches a register that stores the whole byte.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
   localparam int unsigned LVL_W_DEF = 3;
   localparam int unsigned VEC_W_DEF = 8;
   localparam int unsigned NUM_SRC   = 2;
   localparam int unsigned SRC_SER   = 0;
   localparam int unsigned SRC_SPI   = 1;

   typedef enum logic [1:0] {
      ADR_SER_LVL = 2'd0,
      ADR_SPI_LVL = 2'd1,
      ADR_VECTOR  = 2'd2,
      ADR_RSVD    = 2'd3
   } irq_reg_adr_e;
endpackage

// File: rtl/irq_pair_cfg.sv
module irq_pair_cfg
   import irq_pair_pkg::*;
#(
   parameter int unsigned LVL_W     = LVL_W_DEF,
   parameter int unsigned VEC_W     = VEC_W_DEF,
   parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     sel,
   input  logic                           wr,
   input  logic [VEC_W-1:0]               wdata,
   output logic [VEC_W-1:0]               rdata,
   output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl,
   output logic [VEC_W-1:1]               vec_base
);
   localparam int unsigned PAD_W = VEC_W - LVL_W;

   logic unused_wdata_lsb;
   assign unused_wdata_lsb = wdata[0];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
      localparam logic [1:0] MY_ADR = (s == SRC_SPI) ? ADR_SPI_LVL : ADR_SER_LVL;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lvl[s] <= '0;
         else if (wr && sel == MY_ADR)
            lvl[s] <= wdata[LVL_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         vec_base <= VEC_RST[VEC_W-1:1];
      else if (wr && sel == ADR_VECTOR)
         vec_base <= wdata[VEC_W-1:1];
   end

   always_comb begin
      unique case (sel)
         ADR_SER_LVL: rdata = {{PAD_W{1'b0}}, lvl[SRC_SER]};
         ADR_SPI_LVL: rdata = {{PAD_W{1'b0}}, lvl[SRC_SPI]};
         ADR_VECTOR:  rdata = {vec_base, 1'b1};
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_pair_arb.sv
module irq_pair_arb
   import irq_pair_pkg::*;
#(
   parameter int unsigned LVL_W = LVL_W_DEF,
   parameter int unsigned LINES = (1 << LVL_W) - 1
) (
   input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
   input  logic [NUM_SRC-1:0]            pend,
   output logic [LINES-1:0]              irq_req
);
   logic [NUM_SRC-1:0] live;
   logic [LVL_W-1:0]   win_lvl;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_live
      assign live[s] = pend[s] && (lvl[s] != '0);
   end

   always_comb begin
      win_lvl = '0;
      if (live[SRC_SPI] && (!live[SRC_SER] || lvl[SRC_SPI] >= lvl[SRC_SER]))
         win_lvl = lvl[SRC_SPI];
      else if (live[SRC_SER])
         win_lvl = lvl[SRC_SER];
   end

   for (genvar k = 0; k < LINES; k++) begin : g_line
      assign irq_req[k] = (win_lvl == LVL_W'(k + 1));
   end
endmodule

// File: rtl/irq_pair_ack.sv
module irq_pair_ack
   import irq_pair_pkg::*;
#(
   parameter int unsigned LVL_W = LVL_W_DEF,
   parameter int unsigned VEC_W = VEC_W_DEF
) (
   input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
   input  logic [NUM_SRC-1:0]            pend,
   input  logic [VEC_W-1:1]              vec_base,
   input  logic                          iack,
   input  logic [LVL_W-1:0]              iack_lvl,
   output logic                          vec_valid,
   output logic [VEC_W-1:0]              vec_out
);
   logic [NUM_SRC-1:0] hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign hit[s] = iack && pend[s] && (lvl[s] != '0) && (lvl[s] == iack_lvl);
   end

   always_comb begin
      vec_valid = |hit;
      vec_out   = '0;
      if (hit[SRC_SPI])
         vec_out = {vec_base, 1'b1};
      else if (hit[SRC_SER])
         vec_out = {vec_base, 1'b0};
   end
endmodule

// File: rtl/irq_pair_merge.sv
module irq_pair_merge
   import irq_pair_pkg::*;
#(
   parameter int unsigned LVL_W   = LVL_W_DEF,
   parameter int unsigned VEC_W   = VEC_W_DEF,
   parameter logic [7:0]  VEC_RST = 8'h0F,
   parameter int unsigned LINES   = (1 << LVL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_sel,
   input  logic             reg_wr,
   input  logic [VEC_W-1:0] reg_wdata,
   output logic [VEC_W-1:0] reg_rdata,
   input  logic             ser_pend,
   input  logic             spi_pend,
   output logic [LINES-1:0] irq_req,
   input  logic             iack,
   input  logic [LVL_W-1:0] iack_lvl,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_out
);
   if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
      $error("irq_pair_merge: LVL_W must be 1..4");
   end
   if (VEC_W <= LVL_W || VEC_W < 2) begin : g_bad_vec
      $error("irq_pair_merge: VEC_W must exceed LVL_W");
   end
   if (LINES != (1 << LVL_W) - 1) begin : g_bad_lines
      $error("irq_pair_merge: LINES is derived, do not override");
   end

   logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
   logic [VEC_W-1:1]              vec_base;
   logic [NUM_SRC-1:0]            pend;

   assign pend[SRC_SER] = ser_pend;
   assign pend[SRC_SPI] = spi_pend;

   irq_pair_cfg #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_RST(VEC_W'(VEC_RST))) u_cfg (
      .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
      .rdata(reg_rdata), .lvl(lvl), .vec_base(vec_base)
   );

   irq_pair_arb #(.LVL_W(LVL_W), .LINES(LINES)) u_arb (
      .lvl(lvl), .pend(pend), .irq_req(irq_req)
   );

   irq_pair_ack #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
      .lvl(lvl), .pend(pend), .vec_base(vec_base), .iack(iack), .iack_lvl(iack_lvl),
      .vec_valid(vec_valid), .vec_out(vec_out)
   );
endmodule

// File: rtl/irq_pair_merge_chk.sv
module irq_pair_merge_chk #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned VEC_W = 8,
   parameter int unsigned LINES = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       reg_sel,
   input logic [VEC_W-1:0] reg_rdata,
   input logic [LINES-1:0] irq_req,
   input logic             iack,
   input logic [LVL_W-1:0] iack_lvl,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vec_out
);
   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_req == '0);

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel != 2'd2) |-> reg_rdata[VEC_W-1:LVL_W] == '0);

   assert_vec_lsb_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd2) |-> reg_rdata[0]);

   assert_one_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_req));

   assert_valid_needs_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (iack && iack_lvl != '0));

   assert_quiet_no_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> vec_out == '0);
endmodule

bind irq_pair_merge irq_pair_merge_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W), .LINES(LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata), .irq_req(irq_req),
   .iack(iack), .iack_lvl(iack_lvl), .vec_valid(vec_valid), .vec_out(vec_out)
);

// File: tb/irq_pair_merge_test.sv
`timescale 1ns/1ps
module irq_pair_merge_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ser_pend = 1'b0;
   logic       spi_pend = 1'b0;
   logic [6:0] irq_req;
   logic       iack = 1'b0;
   logic [2:0] iack_lvl = '0;
   logic       vec_valid;
   logic [7:0] vec_out;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   irq_pair_merge uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ser_pend(ser_pend), .spi_pend(spi_pend), .irq_req(irq_req),
      .iack(iack), .iack_lvl(iack_lvl), .vec_valid(vec_valid), .vec_out(vec_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
      @(negedge clk);
      reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   task automatic ack(input logic [2:0] l, output logic v, output logic [7:0] vo);
      @(negedge clk);
      iack = 1'b1; iack_lvl = l;
      #1 v = vec_valid; vo = vec_out;
      @(negedge clk);
      iack = 1'b0; iack_lvl = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd_reg(2'd0, d); check("R1 serial level", d, 8'h00);
      rd_reg(2'd1, d); check("R1 spi level", d, 8'h00);
      rd_reg(2'd2, d); check("R1 vector", d, 8'h0F);
      ser_pend = 1'b1; spi_pend = 1'b1; #1;
      check("R1 no request with levels 0", {1'b0, irq_req}, 8'h00);
      ser_pend = 1'b0; spi_pend = 1'b0;
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr_reg(2'd0, 8'hFD); rd_reg(2'd0, d); check("R2 serial reserved bits", d, 8'h05);
      wr_reg(2'd1, 8'h7A); rd_reg(2'd1, d); check("R2 spi reserved bits", d, 8'h02);
      rd_reg(2'd3, d); check("R2 reserved address", d, 8'h00);
      wr_reg(2'd2, 8'h40); rd_reg(2'd2, d); check("R3 vector lsb reads one", d, 8'h41);
      wr_reg(2'd2, 8'hA6); rd_reg(2'd2, d); check("R3 vector write", d, 8'hA7);
   endtask

   task automatic t_single();
      wr_reg(2'd0, 8'h03); wr_reg(2'd1, 8'h00);
      ser_pend = 1'b1; #1;
      check("R4 serial level 3 line", {1'b0, irq_req}, 8'h04);
      spi_pend = 1'b1; #1;
      check("R4 spi level 0 silent", {1'b0, irq_req}, 8'h04);
      ser_pend = 1'b0; spi_pend = 1'b0; #1;
      check("R4 not pending silent", {1'b0, irq_req}, 8'h00);
      wr_reg(2'd1, 8'h07); spi_pend = 1'b1; #1;
      check("R4 spi level 7 line", {1'b0, irq_req}, 8'h40);
      spi_pend = 1'b0;
   endtask

   task automatic t_priority();
      wr_reg(2'd0, 8'h05); wr_reg(2'd1, 8'h02);
      ser_pend = 1'b1; spi_pend = 1'b1; #1;
      check("R5 serial higher", {1'b0, irq_req}, 8'h10);
      wr_reg(2'd1, 8'h06); #1;
      check("R5 spi higher", {1'b0, irq_req}, 8'h20);
      ser_pend = 1'b0; spi_pend = 1'b0;
   endtask

   task automatic t_ack();
      logic v; logic [7:0] vo;
      wr_reg(2'd2, 8'hA6); wr_reg(2'd0, 8'h03); wr_reg(2'd1, 8'h06);
      ser_pend = 1'b1; spi_pend = 1'b1;
      ack(3'd3, v, vo);
      check("R7 serial ack valid", {7'd0, v}, 8'h01);
      check("R7 serial vector", vo, 8'hA6);
      ack(3'd6, v, vo);
      check("R7 spi ack valid", {7'd0, v}, 8'h01);
      check("R7 spi vector", vo, 8'hA7);
      #1 check("R11 request persists", {1'b0, irq_req}, 8'h20);
      ack(3'd2, v, vo);
      check("R9 no match valid", {7'd0, v}, 8'h00);
      check("R9 no match vector", vo, 8'h00);
      spi_pend = 1'b0;
      ack(3'd6, v, vo);
      check("R9 level of idle source", {7'd0, v}, 8'h00);
      ser_pend = 1'b0;
   endtask

   task automatic t_tie();
      logic v; logic [7:0] vo;
      wr_reg(2'd2, 8'h30); wr_reg(2'd0, 8'h04); wr_reg(2'd1, 8'h04);
      ser_pend = 1'b1; spi_pend = 1'b1; #1;
      check("R6 tie one line", {1'b0, irq_req}, 8'h08);
      ack(3'd4, v, vo);
      check("R8 tie valid", {7'd0, v}, 8'h01);
      check("R8 tie spi vector", vo, 8'h31);
      spi_pend = 1'b0;
      ack(3'd4, v, vo);
      check("R7 serial after spi drops", vo, 8'h30);
      ser_pend = 1'b0;
   endtask

   task automatic t_level0();
      logic v; logic [7:0] vo;
      wr_reg(2'd0, 8'h00); wr_reg(2'd1, 8'h00);
      ser_pend = 1'b1; spi_pend = 1'b1;
      ack(3'd0, v, vo);
      check("R10 level 0 ack silent", {7'd0, v}, 8'h00);
      check("R10 level 0 vector", vo, 8'h00);
      ser_pend = 1'b0; spi_pend = 1'b0;
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_single();
      t_priority();
      t_ack();
      t_tie();
      t_level0();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule